// File: doc/BRIEF.md
# Auto-Masking Interrupt Vector Controller

This block gathers up to 64 message-signalled interrupt vectors behind a small synchronous register port. The vectors are grouped into banks of 32. Each bank has four write-1 register groups: one sets pending status, one clears it, one sets the mask and one clears it. Status and mask can both be read back. A vector that is pending and unmasked is eligible for delivery. The block offers one eligible vector at a time on a valid/ready message output.

Delivery is self-arming. On the cycle a message is accepted, the vector's pending status is cleared and its mask is set, in a single step. Software must unmask the vector again before it can fire a second time. If software unmasks a vector whose status is already pending, the message goes out at once. If software unmasks a vector that is not pending, nothing is sent.

The message output follows valid/ready rules:
- Once `msg_valid` is high, it stays high and `msg_vector` stays unchanged until `msg_ready` is seen high on a clock edge.
- An offer is committed when it is made. A later software write to the same vector does not withdraw it.
- The sink may hold `msg_ready` low for any number of cycles.

Top module: `msgvec_ctrl`

## Requirements
- R1: After reset, every status bit reads 0, every mask bit reads 1, and `msg_valid` is 0.
- R2: Vector n sits at bank n/32, bit n%32 in every register group. `cfg_addr` is {bank, group}, with the group in the two low bits: 0 sets status, 1 clears status, 2 sets the mask, 3 clears the mask.
- R3: On a write, each 1 bit of `cfg_wdata` applies that group's action to its vector. Each 0 bit leaves its vector unchanged.
- R4: A read of group 0 or 1 returns the bank's status, and a read of group 2 or 3 returns its mask. The word appears on `cfg_rdata` one cycle after `cfg_re` and holds until the next read. It reflects the state before any write made in the same cycle.
- R5: A vector that is pending with its mask at 1 is never offered.
- R6: When the output is idle, the lowest eligible vector is offered starting one cycle after the state that makes it eligible appears. That is two cycles after the register write that causes it.
- R7: Clearing the mask of a pending vector causes its message. Clearing the mask of a vector that is not pending produces no message.
- R8: When several vectors are eligible, the lowest index is offered first.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and `msg_vector` is stable.
- R10: On the handshake cycle, the offered vector's status is cleared and its mask is set. A status-set write in the same cycle leaves it pending. A mask-clear write in the same cycle leaves it unmasked.
- R11: After each handshake, `msg_valid` is low for exactly one cycle before the next offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 3 | {bank, group} register select |
| cfg_wdata | input | 32 | Write data, one bit per vector |
| cfg_rdata | output | 32 | Registered read data |
| msg_valid | output | 1 | Message offer valid |
| msg_ready | input | 1 | Message sink accepts the offer |
| msg_vector | output | 6 | Index of the offered vector |

## Verification
Timing is counted from the register edge that captures a write:
- Status and mask change on that edge.
- Read data is due one edge after `cfg_re`.
- An offer caused by a write is due one edge after the state change, so two edges after the write.
- After a handshake, the output is low for the following cycle.

The bench keeps a behavioural model that steps on each rising edge using the inputs held since the last falling edge. It compares the outputs a quarter period after the edge, once every register on the path has settled.

The directed checks drive inputs at falling edges and sample there. They count each expected latency explicitly. These cases include unmask-with-pending, unmask-without-pending, and writes landing on the handshake cycle.

// File: rtl/msgvec_pkg.sv
package msgvec_pkg;
  localparam int GRP_W = 2;

  typedef enum logic [GRP_W-1:0] {
    GRP_PEND_SET = 2'd0,
    GRP_PEND_CLR = 2'd1,
    GRP_MASK_SET = 2'd2,
    GRP_MASK_CLR = 2'd3
  } grp_e;
endpackage

// File: rtl/msgvec_bank.sv
module msgvec_bank
  import msgvec_pkg::*;
#(
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  grp_e          wr_grp,
  input  logic [BW-1:0] wr_data,
  input  logic [BW-1:0] ack_bits,
  output logic [BW-1:0] pend_q,
  output logic [BW-1:0] mask_q
);
  logic [BW-1:0] pset, pclr, mset, mclr;
  logic [BW-1:0] pend_d, mask_d;

  always_comb begin
    pset = '0;
    pclr = '0;
    mset = '0;
    mclr = '0;
    if (wr_en) begin
      unique case (wr_grp)
        GRP_PEND_SET: pset = wr_data;
        GRP_PEND_CLR: pclr = wr_data;
        GRP_MASK_SET: mset = wr_data;
        GRP_MASK_CLR: mclr = wr_data;
        default: ;
      endcase
    end
  end

  // Auto-update from the handshake first, software write on top of it.
  always_comb begin
    pend_d = ((pend_q & ~ack_bits) & ~pclr) | pset;
    mask_d = ((mask_q | ack_bits) | mset) & ~mclr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  // R10: accepted vector leaves pending unless a set write lands with it
  a_r10_ack_clears_pend: assert property (@(posedge clk) disable iff (rst)
    (ack_bits != '0) |=> ((pend_q & $past(ack_bits & ~pset)) == '0));

  // R10: accepted vector becomes masked unless a mask-clear write lands with it
  a_r10_ack_sets_mask: assert property (@(posedge clk) disable iff (rst)
    (ack_bits != '0) |=> ((mask_q & $past(ack_bits & ~mclr)) == $past(ack_bits & ~mclr)));

  // R3: set bits always end up pending
  a_r3_set_lands: assert property (@(posedge clk) disable iff (rst)
    (pset != '0) |=> ((pend_q & $past(pset)) == $past(pset)));
endmodule

// File: rtl/msgvec_pick.sv
module msgvec_pick #(
  parameter int NV = 64,
  parameter int IW = 6
) (
  input  logic [NV-1:0] elig,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Scan downward so the lowest set bit is written last and wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NV - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/msgvec_issue.sv
module msgvec_issue #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          found,
  input  logic [IW-1:0] idx,
  input  logic          ready,
  output logic          valid,
  output logic [IW-1:0] vector,
  output logic          fire
);
  assign fire = valid & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      vector <= '0;
    end else if (fire) begin
      valid <= 1'b0;
    end else if (!valid && found) begin
      valid  <= 1'b1;
      vector <= idx;
    end
  end

  // R9: offer held stable under back-pressure
  a_r9_hold_offer: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(vector)));

  // R11: one idle cycle after every accepted message
  a_r11_bubble: assert property (@(posedge clk) disable iff (rst)
    fire |=> !valid);
endmodule

// File: rtl/msgvec_ctrl.sv
module msgvec_ctrl
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 64,
  parameter int BANK_W  = 32,
  localparam int NUM_BANKS = NUM_VEC / BANK_W,
  localparam int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W    = BSEL_W + GRP_W,
  localparam int IDX_W     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_re,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BANK_W-1:0] cfg_wdata,
  output logic [BANK_W-1:0] cfg_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [IDX_W-1:0]  msg_vector
);
  logic [BSEL_W-1:0]  bank_sel;
  grp_e               grp;
  logic [NUM_VEC-1:0] pend_all, mask_all, elig, ack_vec;
  logic               found, fire;
  logic [IDX_W-1:0]   pick_idx;
  logic [BANK_W-1:0]  rd_word;

  assign bank_sel = cfg_addr[ADDR_W-1:GRP_W];
  assign grp      = grp_e'(cfg_addr[GRP_W-1:0]);
  assign ack_vec  = fire ? (NUM_VEC'(1) << msg_vector) : '0;
  assign elig     = pend_all & ~mask_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    msgvec_bank #(.BW(BANK_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we && (bank_sel == BSEL_W'(b))),
      .wr_grp  (grp),
      .wr_data (cfg_wdata),
      .ack_bits(ack_vec[b*BANK_W +: BANK_W]),
      .pend_q  (pend_all[b*BANK_W +: BANK_W]),
      .mask_q  (mask_all[b*BANK_W +: BANK_W])
    );
  end

  msgvec_pick #(.NV(NUM_VEC), .IW(IDX_W)) u_pick (
    .elig (elig),
    .found(found),
    .idx  (pick_idx)
  );

  msgvec_issue #(.IW(IDX_W)) u_issue (
    .clk   (clk),
    .rst   (rst),
    .found (found),
    .idx   (pick_idx),
    .ready (msg_ready),
    .valid (msg_valid),
    .vector(msg_vector),
    .fire  (fire)
  );

  // Read mux: groups with the high bit set return the mask.
  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_sel == BSEL_W'(b)) begin
        rd_word = grp[1] ? mask_all[b*BANK_W +: BANK_W] : pend_all[b*BANK_W +: BANK_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else if (cfg_re) cfg_rdata <= rd_word;
  end

  // R5: the picked vector is pending and unmasked
  a_r5_pick_unmasked: assert property (@(posedge clk) disable iff (rst)
    found |-> (pend_all[pick_idx] && !mask_all[pick_idx]));

  // R8: nothing eligible below the picked index
  a_r8_lowest_first: assert property (@(posedge clk) disable iff (rst)
    found |-> ((elig & ((NUM_VEC'(1) << pick_idx) - NUM_VEC'(1))) == '0));

  // R6: an idle output takes the pick on the next edge
  a_r6_offer_follows: assert property (@(posedge clk) disable iff (rst)
    (!msg_valid && found) |=> (msg_valid && (msg_vector == $past(pick_idx))));

  // R1: no offer in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !msg_valid);
endmodule

// File: tb/msgvec_ctrl_bench.sv
module msgvec_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 64;
  localparam int BW    = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0, cfg_re = 1'b0, msg_ready = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [BW-1:0] cfg_wdata = '0;
  logic [BW-1:0] cfg_rdata;
  logic          msg_valid;
  logic [5:0]    msg_vector;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  msgvec_ctrl u_msgvec_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [NV-1:0] m_pend, m_mask, op, om;
  logic          m_valid;
  int            m_vec;
  logic [BW-1:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_pend = '0; m_mask = '1; m_valid = 0; m_vec = 0; m_rd = '0;
    end else begin
      op = m_pend; om = m_mask;
      if (cfg_re) m_rd = (cfg_addr[1:0] < 2) ? op[cfg_addr[2]*BW +: BW] : om[cfg_addr[2]*BW +: BW];
      if (m_valid && msg_ready) begin
        m_pend[m_vec] = 1'b0; m_mask[m_vec] = 1'b1; m_valid = 0;
      end else if (!m_valid) begin
        for (int i = 0; i < NV; i++) begin
          if (op[i] && !om[i]) begin m_valid = 1; m_vec = i; break; end
        end
      end
      if (cfg_we) begin
        for (int j = 0; j < BW; j++) begin
          if (cfg_wdata[j]) begin
            case (cfg_addr[1:0])
              2'd0: m_pend[cfg_addr[2]*BW + j] = 1'b1;
              2'd1: m_pend[cfg_addr[2]*BW + j] = 1'b0;
              2'd2: m_mask[cfg_addr[2]*BW + j] = 1'b1;
              default: m_mask[cfg_addr[2]*BW + j] = 1'b0;
            endcase
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    if (!rst) begin
      check("R6 model valid", 64'(msg_valid), 64'(m_valid));
      if (m_valid) check("R8 model vector", 64'(msg_vector), 64'(m_vec));
      check("R4 model rdata", 64'(cfg_rdata), 64'(m_rd));
    end
  end

  task automatic wr(input int b, input int g, input logic [BW-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(b*4 + g); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_wdata = '0;
  endtask

  task automatic rd(input int b, input int g);
    @(negedge clk);
    cfg_re = 1; cfg_addr = 3'(b*4 + g);
    @(negedge clk);
    cfg_re = 0;
  endtask

  task automatic ack;
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
  endtask

  int got[$];
  bit b2b;
  logic prev_v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 valid", 64'(msg_valid), 0);
    rd(0, 0); check("R1 status", 64'(cfg_rdata), 0);
    rd(1, 2); check("R1 mask", 64'(cfg_rdata), 64'hFFFF_FFFF);

    // masked pending vector 4
    wr(0, 0, 32'h10);
    repeat (4) begin @(negedge clk); check("R5 masked silent", 64'(msg_valid), 0); end
    rd(0, 0); check("R2 bank0 bit4", 64'(cfg_rdata), 64'h10);
    wr(0, 0, 32'h0);
    wr(0, 1, 32'h0);
    rd(0, 1); check("R3 zero bits", 64'(cfg_rdata), 64'h10);

    // unmask pending vector 4
    wr(0, 3, 32'h10);
    @(negedge clk);
    check("R7 unmask pending", 64'(msg_valid), 1);
    check("R7 vector", 64'(msg_vector), 4);
    repeat (3) begin
      @(negedge clk);
      check("R9 hold valid", 64'(msg_valid), 1);
      check("R9 hold vector", 64'(msg_vector), 4);
    end
    ack();
    rd(0, 0); check("R10 status cleared", 64'(cfg_rdata), 0);
    rd(0, 2); check("R10 mask set", 64'(cfg_rdata), 64'hFFFF_FFFF);

    // unmask non-pending vector 35
    wr(1, 3, 32'h8);
    repeat (4) begin @(negedge clk); check("R7 unmask idle", 64'(msg_valid), 0); end
    wr(1, 0, 32'h8);
    @(negedge clk);
    check("R6 set fires", 64'(msg_valid), 1);
    check("R2 vector 35", 64'(msg_vector), 35);
    ack();

    // priority and bubble: vectors 1, 2, 8
    wr(0, 0, 32'h106);
    wr(0, 3, 32'h106);
    msg_ready = 1; prev_v = 0; b2b = 0;
    repeat (10) begin
      @(negedge clk);
      if (msg_valid) got.push_back(int'(msg_vector));
      if (msg_valid && prev_v) b2b = 1;
      prev_v = msg_valid;
    end
    msg_ready = 0;
    check("R8 count", 64'(got.size()), 3);
    if (got.size() == 3) begin
      check("R8 first", 64'(got[0]), 1);
      check("R8 second", 64'(got[1]), 2);
      check("R8 third", 64'(got[2]), 8);
    end
    check("R11 bubble", 64'(b2b), 0);

    // status set on the handshake cycle, vector 5
    wr(0, 0, 32'h20);
    wr(0, 3, 32'h20);
    @(negedge clk);
    check("R10 offer 5", 64'(msg_vector), 5);
    msg_ready = 1; cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = 32'h20;
    @(negedge clk);
    msg_ready = 0; cfg_we = 0; cfg_wdata = '0;
    rd(0, 0); check("R10 set on ack", 64'(cfg_rdata), 64'h20);
    rd(0, 2); check("R10 mask on ack", 64'(cfg_rdata), 64'hFFFF_FFFF);
    check("R10 no refire", 64'(msg_valid), 0);

    // mask clear on the handshake cycle, vector 6
    wr(0, 0, 32'h40);
    wr(0, 3, 32'h40);
    @(negedge clk);
    check("R10 offer 6", 64'(msg_vector), 6);
    msg_ready = 1; cfg_we = 1; cfg_addr = 3'd3; cfg_wdata = 32'h40;
    @(negedge clk);
    msg_ready = 0; cfg_we = 0; cfg_wdata = '0;
    rd(0, 2); check("R10 mask clear on ack", 64'(cfg_rdata), 64'hFFFF_FFBF);
    rd(0, 0); check("R10 status after", 64'(cfg_rdata), 64'h20);
    repeat (3) begin @(negedge clk); check("R10 quiet", 64'(msg_valid), 0); end

    // read and write in the same cycle
    @(negedge clk);
    cfg_re = 1; cfg_we = 1; cfg_addr = 3'd4; cfg_wdata = 32'h100;
    @(negedge clk);
    cfg_re = 0; cfg_we = 0; cfg_wdata = '0;
    check("R4 pre-write read", 64'(cfg_rdata), 0);
    rd(1, 1); check("R4 status group1", 64'(cfg_rdata), 64'h100);
    wr(1, 1, 32'h100);
    rd(1, 0); check("R3 clear", 64'(cfg_rdata), 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R6 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule